// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block guards a processor against runaway software. A counter advances on each single-cycle tick from a slow oscillator. When it reaches the end of the selected period, the block raises a one-cycle reset request. Software holds the request off by writing one exact key byte to a restart register. Any other write to that register is treated as a runaway and causes an immediate reset request. Reading the restart register never shows the key. It always returns a fixed pattern. A read-modify-write of that register therefore always writes back a wrong value.

A mode register selects the overflow period. It accepts one full-byte write after each reset and then locks, and a flag on a port shows the lock. A strap picks how the block behaves while the chip is in a low-power state. In one setting counting goes on and an overflow still resets the chip. In the other setting the count is held and resumes from the same value when the low-power state ends.

Top module: `keyed_wdog`

## Requirements
- R1: A full-byte write of 0xAC to the restart register (address 1) clears the count to zero, so the next overflow comes a full period after that write.
- R2: A full-byte write of any other value to the restart register sets `rst_req` in the following cycle.
- R3: A write to the restart register with `bitop` high sets `rst_req` in the following cycle, whatever the data.
- R4: A read of address 1 returns 0x9A. A read of address 0 returns the period field in bits [2:0] with zeros above it. A read of any other address returns 0.
- R5: The period field is written from `wdata[2:0]` at address 0. With value N, the overflow comes on the 2^(10+N)-th counted tick after a restart.
- R6: After reset, the first full-byte write to address 0 is stored and sets `mode_locked`. Later writes to address 0 leave the field unchanged.
- R7: A write to address 0 with `bitop` high is ignored and does not set the lock.
- R8: `rst_req` is high for exactly one cycle. In that cycle the field reads 7, `mode_locked` is 0 and the count is zero.
- R9: The count advances only in cycles where `tick` is high.
- R10: With `lp_freeze_strap` low, ticks are counted while `lp_active` is high, and an overflow then still raises `rst_req`.
- R11: With `lp_freeze_strap` high, ticks are not counted while `lp_active` is high. Counting resumes from the held value when `lp_active` falls.
- R12: An overflow of the count sets `rst_req` in the cycle after the last counted tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle count enable from the slow oscillator |
| addr | input | ADDR_W | Register address (0 = mode, 1 = restart) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| bitop | input | 1 | Qualifier marking a write as a single-bit operation |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational on `rd_en` and `addr` |
| lp_freeze_strap | input | 1 | 1: hold the count in low-power states; 0: keep counting |
| lp_active | input | 1 | High while the chip is in a halt or stop state |
| rst_req | output | 1 | One-cycle reset request |
| mode_locked | output | 1 | Mode register has taken its single write |

## Verification
The count itself is not visible at the ports. A wrong count can only be seen in the timing of `rst_req`. A counter that is off by one tick, or that fails to clear, moves the pulse by that many ticks. The bench therefore checks the cycle before the expected overflow and the overflow cycle itself. A wrong lock state or a wrong period field shows up on the next readback of address 0 and on `mode_locked` in the cycle after the write. A decode fault on the restart register shows up as a missing or unexpected `rst_req` one cycle after the write.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int DATA_W    = 8;
  localparam int SEL_W     = 3;
  localparam int BASE_EXP  = 10;
  localparam int CNT_W     = BASE_EXP + (1 << SEL_W) - 1;

  localparam logic [DATA_W-1:0] RESTART_KEY  = 8'hAC;
  localparam logic [DATA_W-1:0] RESTART_SHOW = 8'h9A;
  localparam logic [SEL_W-1:0]  SEL_DEFAULT  = '1;

  typedef enum logic [1:0] {
    REG_MODE    = 2'd0,
    REG_RESTART = 2'd1
  } reg_id_e;

  // last count value of a period of 2^(BASE_EXP+sel) ticks
  function automatic logic [CNT_W-1:0] last_count(input logic [SEL_W-1:0] sel);
    logic [31:0] full;
    full = (32'd1 << (BASE_EXP + int'(sel))) - 32'd1;
    return full[CNT_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] mode_view(input logic [SEL_W-1:0] sel);
    return {{(DATA_W-SEL_W){1'b0}}, sel};
  endfunction
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_clr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic                 bitop,
  input  logic [DATA_W-1:0]    wdata,
  output logic [SEL_W-1:0]     period_sel,
  output logic                 mode_locked,
  output logic                 restart_ok,
  output logic                 key_fault,
  output logic [DATA_W-1:0]    rdata
);
  localparam logic [ADDR_W-1:0] A_MODE    = ADDR_W'(REG_MODE);
  localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(REG_RESTART);

  logic mode_hit, restart_hit, mode_accept;

  assign mode_hit    = wr_en && (addr == A_MODE);
  assign restart_hit = wr_en && (addr == A_RESTART);
  assign mode_accept = mode_hit && !bitop && !mode_locked;
  assign restart_ok  = restart_hit && !bitop && (wdata == RESTART_KEY);
  assign key_fault   = restart_hit && !restart_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_sel  <= SEL_DEFAULT;
      mode_locked <= 1'b0;
    end else if (soft_clr) begin
      period_sel  <= SEL_DEFAULT;
      mode_locked <= 1'b0;
    end else if (mode_accept) begin
      period_sel  <= wdata[SEL_W-1:0];
      mode_locked <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == A_MODE)         rdata = mode_view(period_sel);
      else if (addr == A_RESTART) rdata = RESTART_SHOW;
    end
  end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
  import kwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run_en,
  input  logic              clear,
  input  logic [SEL_W-1:0]  period_sel,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_evt
);
  logic step;

  assign step    = tick && run_en;
  assign ovf_evt = step && (count >= last_count(period_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (step)  count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              bitop,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              lp_freeze_strap,
  input  logic              lp_active,
  output logic              rst_req,
  output logic              mode_locked
);
  logic [SEL_W-1:0] period_sel;
  logic [CNT_W-1:0] count;
  logic restart_ok, key_fault, ovf_evt, fault, run_en, clr_cnt;

  assign fault   = key_fault | ovf_evt;
  assign run_en  = !(lp_freeze_strap && lp_active);
  assign clr_cnt = restart_ok | fault;

  kwd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_clr(fault),
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .bitop(bitop), .wdata(wdata),
    .period_sel(period_sel), .mode_locked(mode_locked),
    .restart_ok(restart_ok), .key_fault(key_fault), .rdata(rdata)
  );

  kwd_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_en), .clear(clr_cnt),
    .period_sel(period_sel), .count(count), .ovf_evt(ovf_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= fault;
  end
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rdata,
  input logic              lp_freeze_strap,
  input logic              lp_active,
  input logic              rst_req,
  input logic              mode_locked,
  input logic              key_fault,
  input logic              restart_ok,
  input logic              ovf_evt,
  input logic [CNT_W-1:0]  count,
  input logic [SEL_W-1:0]  period_sel
);
  assert_key_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_fault |=> rst_req);

  assert_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> rst_req);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (!rst_req || $past(key_fault)));

  assert_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (!mode_locked && count == '0 && period_sel == SEL_DEFAULT));

  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_locked && !key_fault && !ovf_evt) |=> $stable(period_sel));

  assert_restart_view_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(REG_RESTART)) |-> rdata == RESTART_SHOW);

  assert_tick_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart_ok && !key_fault) |=> $stable(count));

  assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_freeze_strap && lp_active && !restart_ok && !key_fault) |=> $stable(count));

  assert_restart_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    restart_ok |=> (count == '0));
endmodule

bind keyed_wdog kwd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .lp_freeze_strap(lp_freeze_strap), .lp_active(lp_active),
  .rst_req(rst_req), .mode_locked(mode_locked), .key_fault(key_fault),
  .restart_ok(restart_ok), .ovf_evt(ovf_evt), .count(count),
  .period_sel(period_sel)
);

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {addr[3:0], bitop[3:0], wdata[7:0], exp_rst[3:0], exp_lock[3:0], exp_mode[7:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h01030007,  // R7 bit-op mode write ignored
    32'h00000100,  // R6 first write stored and locks
    32'h00050100,  // R6 second write ignored
    32'h10AC0100,  // R1 key accepted, no reset
    32'h109A1007,  // R2 read-back value written back resets
    32'h11AC1007,  // R3 bit-op write of key still resets
    32'h00020102,  // R6 unlocked again after reset
    32'h10001007   // R2 wrong key
  };

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0, bitop = 0;
  logic lp_freeze_strap = 0, lp_active = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rst_req, mode_locked;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  keyed_wdog u_keyed_wdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .bitop(bitop), .wdata(wdata), .rdata(rdata),
    .lp_freeze_strap(lp_freeze_strap), .lp_active(lp_active),
    .rst_req(rst_req), .mode_locked(mode_locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic bo, input logic [7:0] d);
    @(negedge clk);
    addr = a; bitop = bo; wdata = d; wr_en = 1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; bitop = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1;
    #1 d = rdata;
    rd_en = 0;
  endtask

  // n counted tick edges; returns at the negedge after the last one
  task automatic ticks(input int n);
    tick = 1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick = 0;
  endtask

  // period 2^(10+n): expect no pulse one tick early, pulse on the last tick
  task automatic expect_overflow(input string req, input int pre, input int n);
    int full;
    full = (1 << (10 + n)) - pre;
    ticks(full - 1);
    check(req, rst_req, 1'b0);
    ticks(1);
    check(req, rst_req, 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 reset rst_req", rst_req, 1'b0);
    check("R8 reset lock", mode_locked, 1'b0);
    bus_read(2'd0, rd); check("R8 reset mode", rd, 8'h07);
    bus_read(2'd1, rd); check("R4 restart view", rd, 8'h9A);
    bus_read(2'd2, rd); check("R4 unused addr", rd, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      bus_write(VEC[i][29:28], VEC[i][24], VEC[i][23:16]);
      check($sformatf("R2 vec%0d rst_req", i), rst_req, VEC[i][12]);
      check($sformatf("R6 vec%0d lock", i), mode_locked, VEC[i][8]);
      bus_read(2'd0, rd);
      check($sformatf("R7 vec%0d mode", i), rd, VEC[i][7:0]);
    end
    @(negedge clk);
    check("R8 pulse width", rst_req, 1'b0);

    // R5 and R12: N=0 period
    bus_write(2'd0, 0, 8'h00);
    bus_write(2'd1, 0, 8'hAC);
    expect_overflow("R12 N0 overflow", 0, 0);
    @(negedge clk);
    check("R8 after overflow pulse", rst_req, 1'b0);
    check("R8 after overflow lock", mode_locked, 1'b0);

    // R1: restart part way through restarts the full period
    bus_write(2'd0, 0, 8'h00);
    bus_write(2'd1, 0, 8'hAC);
    ticks(1000);
    bus_write(2'd1, 0, 8'hAC);
    expect_overflow("R1 restart clears", 0, 0);

    // R9: idle cycles without tick do not count
    bus_write(2'd0, 0, 8'h00);
    bus_write(2'd1, 0, 8'hAC);
    ticks(1000);
    repeat (2000) @(negedge clk);
    check("R9 no count without tick", rst_req, 1'b0);
    expect_overflow("R9 resume", 1000, 0);

    // R11: freeze strap holds the count in low power
    lp_freeze_strap = 1;
    bus_write(2'd0, 0, 8'h00);
    bus_write(2'd1, 0, 8'hAC);
    ticks(500);
    lp_active = 1;
    ticks(1500);
    check("R11 frozen", rst_req, 1'b0);
    lp_active = 0;
    expect_overflow("R11 resumes held count", 500, 0);

    // R10: continue strap counts in low power and resets there
    lp_freeze_strap = 0;
    bus_write(2'd0, 0, 8'h00);
    bus_write(2'd1, 0, 8'hAC);
    ticks(500);
    lp_active = 1;
    expect_overflow("R10 counts in low power", 500, 0);
    lp_active = 0;

    // R5: N=1 doubles the period
    bus_write(2'd0, 0, 8'h01);
    bus_write(2'd1, 0, 8'hAC);
    expect_overflow("R5 N1 period", 0, 1);

    // R5: default N=7 after reset, no mode write
    bus_write(2'd1, 0, 8'hAC);
    expect_overflow("R5 N7 default period", 0, 7);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule